// File: doc/BRIEF.md
# Hash Engine Command Register File

This block is the software-facing control register set of a hash accelerator. A host writes and reads it over a simple 32-bit bus that carries word addresses. The block holds the job parameters: source address, destination address, key buffer address, source length and a separate cipher command word. Each parameter is masked to its legal width or alignment when it is written. The hashing datapath reads these registers directly and is not part of this block.

A write to the hash command register stores the word and also tries to launch a job. The algorithm field is decoded in two levels: a base selector, and a variant selector used only for the 512-bit family. If the code is not a legal combination, or a job is still running, the word is stored but nothing is launched. If the code is legal and the engine is idle, the block sends the datapath a one-cycle start pulse together with a registered algorithm code, a scatter-gather flag and an accumulate flag.

When the datapath reports completion, a sticky done flag is set. The interrupt line is raised if the accepted command had its interrupt enable bit set. Software clears the flag by writing 1 to it.

Top module: `hash_cmd_regs`

## Requirements
- R1: After reset every register reads zero, and job_start, job_sg, job_accum, irq and job_algo are all zero.
- R2: Writes are masked per register. Source address at word 8 keeps bits [30:0]. Destination at word 9 and key address at word 10 keep bits [30:3]. Source length at word 11 keeps bits [27:0]. Hash command at word 12 keeps mask 0x00147FFF. Cipher command at word 4 and all other words in range are stored unmasked.
- R3: Command bits [6:4] select the base algorithm, with bits [12:10] zero. 000 gives job_algo 0 (MD5), 010 gives 1 (SHA-1), 100 gives 2 (SHA-224) and 101 gives 3 (SHA-256).
- R4: Base code 110 selects the 512-family, and bits [12:10] then pick the variant. 000 gives job_algo 4 (SHA-512), 001 gives 5 (SHA-384) and 010 gives 6 (SHA-512/256). Every other combination of bits [6:4] and [12:10] is invalid: the word is stored and no job starts.
- R5: job_sg equals command bit 18 of the launched command. job_accum is 1 only when command bits [8:7] equal exactly 10.
- R6: An accepted command raises job_start for exactly one cycle, in the cycle after the write. Status bit 0 (busy) reads 1 from then until job_done is seen.
- R7: A command written while busy is stored but raises no job_start.
- R8: A job_done pulse sets status bit 9 (done) and clears busy.
- R9: Writing status word 7 with bit 9 set clears the done flag. Writing it with bit 9 clear has no effect. A job_done in the same cycle as the clear wins, and the flag stays set.
- R10: irq equals the done flag ANDed with command bit 9 of the last accepted command.
- R11: A word address of 16 or above reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| job_done | input | 1 | Completion pulse from the datapath |
| job_start | output | 1 | One-cycle launch pulse |
| job_algo | output | 3 | Decoded algorithm code of the launched job |
| job_sg | output | 1 | Scatter-gather source mode of the launched job |
| job_accum | output | 1 | Accumulate digest mode of the launched job |
| irq | output | 1 | Level completion interrupt |

## Verification
The hardest case to reach is a collision of events in a single cycle, such as a done report arriving in the same cycle as the software clear of the done flag. The other hard case is a command written while the previous job is still marked busy. The bench drives job_done and the status write in the same clock cycle to test the collision. It holds job_done low across a second command write to test the busy case. In both cases it reads the status word back through the bus. The 512-family codes and the neighbouring illegal codes are walked one by one, and an illegal code is confirmed to leave job_start low.

// File: rtl/hash_regs_pkg.sv
package hash_regs_pkg;
  localparam int IDX_CRYPT  = 4;
  localparam int IDX_STATUS = 7;
  localparam int IDX_SRC    = 8;
  localparam int IDX_DST    = 9;
  localparam int IDX_KEY    = 10;
  localparam int IDX_LEN    = 11;
  localparam int IDX_CMD    = 12;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 9;

  typedef enum logic [2:0] {
    ALG_MD5        = 3'd0,
    ALG_SHA1       = 3'd1,
    ALG_SHA224     = 3'd2,
    ALG_SHA256     = 3'd3,
    ALG_SHA512     = 3'd4,
    ALG_SHA384     = 3'd5,
    ALG_SHA512_256 = 3'd6
  } algo_e;
endpackage

// File: rtl/hash_algo_decode.sv
module hash_algo_decode
  import hash_regs_pkg::*;
(
  input  logic [31:0] cmd,
  output logic        valid,
  output algo_e       algo,
  output logic        sg,
  output logic        accum,
  output logic        irq_en
);
  logic [2:0] base;
  logic [2:0] variant;

  assign base    = cmd[6:4];
  assign variant = cmd[12:10];
  assign sg      = cmd[18];
  assign accum   = (cmd[8:7] == 2'b10);
  assign irq_en  = cmd[9];

  always_comb begin
    valid = 1'b0;
    algo  = ALG_MD5;
    unique case (base)
      3'b000: begin valid = (variant == 3'b000); algo = ALG_MD5;    end
      3'b010: begin valid = (variant == 3'b000); algo = ALG_SHA1;   end
      3'b100: begin valid = (variant == 3'b000); algo = ALG_SHA224; end
      3'b101: begin valid = (variant == 3'b000); algo = ALG_SHA256; end
      3'b110: begin
        unique case (variant)
          3'b000:  begin valid = 1'b1; algo = ALG_SHA512;     end
          3'b001:  begin valid = 1'b1; algo = ALG_SHA384;     end
          3'b010:  begin valid = 1'b1; algo = ALG_SHA512_256; end
          default: begin valid = 1'b0; algo = ALG_MD5;        end
        endcase
      end
      default: begin valid = 1'b0; algo = ALG_MD5; end
    endcase
  end
endmodule

// File: rtl/hash_job_ctl.sv
module hash_job_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic irq_en_in,
  input  logic job_done,
  input  logic clr_done,
  output logic busy,
  output logic done_flag,
  output logic irq
);
  logic busy_d, done_d, irq_en_d, irq_en_q;

  always_comb begin
    busy_d   = busy;
    done_d   = done_flag;
    irq_en_d = irq_en_q;
    if (launch)        busy_d = 1'b1;
    else if (job_done) busy_d = 1'b0;
    if (job_done)      done_d = 1'b1;
    else if (clr_done) done_d = 1'b0;
    if (launch)        irq_en_d = irq_en_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done_flag <= 1'b0;
      irq_en_q  <= 1'b0;
    end else begin
      busy      <= busy_d;
      done_flag <= done_d;
      irq_en_q  <= irq_en_d;
    end
  end

  assign irq = done_flag & irq_en_q;
endmodule

// File: rtl/hash_cmd_regs.sv
module hash_cmd_regs
  import hash_regs_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          NUM_REGS = 16,
  parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] KEY_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] LEN_MASK = 32'h0FFF_FFFF,
  parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              job_done,
  output logic              job_start,
  output logic [2:0]        job_algo,
  output logic              job_sg,
  output logic              job_accum,
  output logic              irq
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  function automatic logic [31:0] mask_for(input int idx);
    case (idx)
      IDX_SRC:    return SRC_MASK;
      IDX_DST:    return DST_MASK;
      IDX_KEY:    return KEY_MASK;
      IDX_LEN:    return LEN_MASK;
      IDX_CMD:    return CMD_MASK;
      IDX_STATUS: return 32'h0;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic             wr_hit, cmd_wr, clr_done;
  logic [31:0]      cmd_masked;

  assign in_range   = (bus_addr <= LAST_ADDR);
  assign idx        = bus_addr[IDX_W-1:0];
  assign wr_hit     = bus_we && in_range && (int'(idx) != IDX_STATUS);
  assign cmd_wr     = bus_we && in_range && (int'(idx) == IDX_CMD);
  assign clr_done   = bus_we && in_range && (int'(idx) == IDX_STATUS)
                      && bus_wdata[STAT_DONE_BIT];
  assign cmd_masked = bus_wdata & CMD_MASK;

  // register storage
  logic [31:0] word_q [NUM_REGS];
  logic [31:0] word_d [NUM_REGS];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) word_d[i] = word_q[i];
    word_d[idx] = bus_wdata & mask_for(int'(idx));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int i = 0; i < NUM_REGS; i++) word_q[i] <= '0;
    end else if (wr_hit) begin
      word_q[idx] <= word_d[idx];
    end
  end

  // command decode and launch
  logic  dec_valid, dec_sg, dec_accum, dec_irq_en;
  algo_e dec_algo;
  logic  busy, done_flag, launch;

  hash_algo_decode u_dec (
    .cmd    (cmd_masked),
    .valid  (dec_valid),
    .algo   (dec_algo),
    .sg     (dec_sg),
    .accum  (dec_accum),
    .irq_en (dec_irq_en)
  );

  assign launch = cmd_wr && dec_valid && !busy;

  hash_job_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_q),
    .launch    (launch),
    .irq_en_in (dec_irq_en),
    .job_done  (job_done),
    .clr_done  (clr_done),
    .busy      (busy),
    .done_flag (done_flag),
    .irq       (irq)
  );

  logic       start_d, sg_d, accum_d;
  logic [2:0] algo_d;

  always_comb begin
    start_d = launch;
    algo_d  = job_algo;
    sg_d    = job_sg;
    accum_d = job_accum;
    if (launch) begin
      algo_d  = dec_algo;
      sg_d    = dec_sg;
      accum_d = dec_accum;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      job_start <= 1'b0;
      job_algo  <= '0;
      job_sg    <= 1'b0;
      job_accum <= 1'b0;
    end else begin
      job_start <= start_d;
      job_algo  <= algo_d;
      job_sg    <= sg_d;
      job_accum <= accum_d;
    end
  end

  // read path
  logic [31:0] status_word;
  always_comb begin
    status_word                = '0;
    status_word[STAT_BUSY_BIT] = busy;
    status_word[STAT_DONE_BIT] = done_flag;
  end

  always_comb begin
    bus_rdata = '0;
    if (in_range) begin
      if (int'(idx) == IDX_STATUS) bus_rdata = status_word;
      else                         bus_rdata = word_q[idx];
    end
  end
endmodule

// File: rtl/hash_cmd_regs_chk.sv
module hash_cmd_regs_chk
  import hash_regs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16
) (
  input logic              clk,
  input logic              rst_q,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              job_done,
  input logic              job_start,
  input logic              irq,
  input logic              busy,
  input logic              done_flag,
  input logic              dec_valid
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(IDX_CMD);

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_q)
    job_start |=> !job_start);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_q)
    job_start |-> busy);

  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == CMD_ADDR && busy) |=> !job_start);

  p_invalid_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == CMD_ADDR && !dec_valid) |=> !job_start);

  p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_q)
    job_done |=> done_flag);

  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> done_flag);

  p_oob_read_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr > LAST_ADDR) |-> (bus_rdata == 32'h0));
endmodule

bind hash_cmd_regs hash_cmd_regs_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_REGS (NUM_REGS)
) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .job_done  (job_done),
  .job_start (job_start),
  .irq       (irq),
  .busy      (busy),
  .done_flag (done_flag),
  .dec_valid (dec_valid)
);

// File: tb/hash_cmd_regs_tb.sv
module hash_cmd_regs_tb;
  localparam int A_CRYPT = 4, A_STAT = 7, A_SRC = 8, A_DST = 9,
                 A_KEY = 10, A_LEN = 11, A_CMD = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        job_done;
  logic        job_start;
  logic [2:0]  job_algo;
  logic        job_sg;
  logic        job_accum;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hash_cmd_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .job_done(job_done),
    .job_start(job_start), .job_algo(job_algo), .job_sg(job_sg),
    .job_accum(job_accum), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 8'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); job_done = 1'b1;
    @(negedge clk); job_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk("R1 reg zero", v, 32'h0);
    end
    chk("R1 outputs", {job_start, job_sg, job_accum, irq, 1'b0, job_algo}, 32'h0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(A_SRC, 32'hFFFF_FFFF);   rd(A_SRC, v);   chk("R2 src", v, 32'h7FFF_FFFF);
    wr(A_DST, 32'hFFFF_FFFF);   rd(A_DST, v);   chk("R2 dst", v, 32'h7FFF_FFF8);
    wr(A_KEY, 32'hFFFF_FFFF);   rd(A_KEY, v);   chk("R2 key", v, 32'h7FFF_FFF8);
    wr(A_LEN, 32'hFFFF_FFFF);   rd(A_LEN, v);   chk("R2 len", v, 32'h0FFF_FFFF);
    wr(A_CRYPT, 32'hDEAD_BEEF); rd(A_CRYPT, v); chk("R2 crypt", v, 32'hDEAD_BEEF);
    wr(A_CMD, 32'hFFFF_FFFF);
    chk("R4 all-ones cmd no start", {31'h0, job_start}, 32'h0);
    rd(A_CMD, v); chk("R2 cmd", v, 32'h0014_7FFF);
  endtask

  task automatic run_cmd(input string req, input logic [31:0] cmd, input bit ok,
                         input logic [2:0] algo, input bit sg, input bit acc);
    logic [31:0] v;
    wr(A_CMD, cmd);
    chk({req, " start"}, {31'h0, job_start}, {31'h0, ok});
    if (ok) begin
      chk({req, " algo"}, {29'h0, job_algo}, {29'h0, algo});
      chk({req, " R5 sg/acc"}, {30'h0, job_sg, job_accum}, {30'h0, sg, acc});
    end
    rd(A_CMD, v); chk({req, " stored"}, v, cmd & 32'h0014_7FFF);
    @(negedge clk);
    chk("R6 pulse one cycle", {31'h0, job_start}, 32'h0);
    if (ok) begin
      pulse_done();
      wr(A_STAT, 32'h200);
    end
  endtask

  task automatic t_decode();
    run_cmd("R3 md5",     32'h0000_0000, 1, 3'd0, 0, 0);
    run_cmd("R3 sha1",    32'h0000_0020, 1, 3'd1, 0, 0);
    run_cmd("R3 sha224",  32'h0000_0040, 1, 3'd2, 0, 0);
    run_cmd("R3 sha256",  32'h0000_0050, 1, 3'd3, 0, 0);
    run_cmd("R4 sha512",  32'h0000_0060, 1, 3'd4, 0, 0);
    run_cmd("R4 sha384",  32'h0000_0460, 1, 3'd5, 0, 0);
    run_cmd("R4 sha512/256", 32'h0000_0860, 1, 3'd6, 0, 0);
    run_cmd("R4 bad variant", 32'h0000_0C60, 0, 3'd0, 0, 0);
    run_cmd("R4 bad base 111", 32'h0000_0070, 0, 3'd0, 0, 0);
    run_cmd("R4 bad base 001", 32'h0000_0010, 0, 3'd0, 0, 0);
    run_cmd("R4 variant on sha1", 32'h0000_0420, 0, 3'd0, 0, 0);
    run_cmd("R5 sg+accum", 32'h0004_0150, 1, 3'd3, 1, 1);
    run_cmd("R5 hmac-key not accum", 32'h0000_01D0, 1, 3'd3, 0, 0);
    run_cmd("R5 hmac not accum", 32'h0000_00A0, 1, 3'd1, 0, 0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(A_CMD, 32'h0000_0020);
    chk("R6 start", {31'h0, job_start}, 32'h1);
    rd(A_STAT, v); chk("R6 busy", v, 32'h1);
    wr(A_CMD, 32'h0000_0050);
    chk("R7 blocked", {31'h0, job_start}, 32'h0);
    chk("R7 algo held", {29'h0, job_algo}, 32'd1);
    rd(A_CMD, v); chk("R7 stored", v, 32'h50);
    pulse_done();
    rd(A_STAT, v); chk("R8 done clears busy", v, 32'h200);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R9 write zero no effect", v, 32'h200);
    wr(A_STAT, 32'h200);
    rd(A_STAT, v); chk("R9 w1c", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(A_CMD, 32'h0000_0220);
    chk("R10 start", {31'h0, job_start}, 32'h1);
    chk("R10 irq low while busy", {31'h0, irq}, 32'h0);
    pulse_done();
    chk("R10 irq high", {31'h0, irq}, 32'h1);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'(A_STAT); bus_wdata = 32'h200; job_done = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; job_done = 1'b0;
    rd(A_STAT, v); chk("R9 set wins over clear", v, 32'h200);
    wr(A_STAT, 32'h200);
    chk("R10 irq dropped by clear", {31'h0, irq}, 32'h0);
    wr(A_CMD, 32'h0000_0020);
    pulse_done();
    rd(A_STAT, v); chk("R8 flag set", v, 32'h200);
    chk("R10 irq disabled", {31'h0, irq}, 32'h0);
    wr(A_STAT, 32'h200);
  endtask

  task automatic t_oob();
    logic [31:0] v;
    wr(A_CRYPT, 32'h1234_5678);
    wr(20, 32'hFFFF_FFFF);
    rd(20, v);      chk("R11 oob read", v, 32'h0);
    rd(A_CRYPT, v); chk("R11 no alias write", v, 32'h1234_5678);
    wr(28, 32'h0000_0020);
    chk("R11 oob cmd no start", {31'h0, job_start}, 32'h0);
    rd(255, v);     chk("R11 top addr", v, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; job_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_masks();
    t_decode();
    t_busy();
    t_irq();
    t_oob();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule